// File: doc/BRIEF.md
# Microprogram Sequencer with Conditional Branching

This block sequences a microprogrammed control unit. A microprogram counter (uPC) addresses an internal control store. Each entry holds one control word, with one bit per datapath control signal, plus sequencing fields: a branch enable, a two-bit condition selector, a branch polarity bit, a dispatch marker and a target address. The control word of the entry the counter currently points at appears on `ctrl_word` in the same cycle. The datapath itself is outside this block.

On each clock edge the counter normally steps by one. It can instead be held, loaded or cleared. A microinstruction that waits for memory holds the counter until `mem_done` is high. An End microinstruction clears the counter to 0, which is the first microinstruction of the fetch routine. The dispatch microinstruction at address 3 loads the start address of the routine that belongs to the opcode. A conditional microbranch loads its target when the selected condition matches its polarity.

The opcode arrives on a valid/ready stream. `instr_ready` is high only while the dispatch microinstruction is current. The opcode is taken on a cycle where `instr_valid` and `instr_ready` are both high. While `instr_valid` is low at dispatch, the sequencer waits there without limit; this is its back-pressure. The producer may raise or drop `instr_valid` at any time. Outside dispatch the stream is not sampled at all.

Top module: `useq_top`

## Requirements
- R1: While `rst_n` is low, the counter is 0, `ctrl_word` is 0x0038D (fetch step 0) and `instr_ready` is low.
- R2: After a microinstruction that is not a wait-for-memory stall, not End, not dispatch and not a branch, the counter increases by one (for example 12 to 13 and 26 to 27).
- R3: While the current microinstruction has the wait-for-memory bit (bit 15) set and `mem_done` is low, the counter holds. On the edge where `mem_done` is high, the counter advances. Fetch step 1 is such a microinstruction.
- R4: `instr_ready` is high only at the dispatch address 3. While `instr_valid` is low there, the counter holds. On a handshake, the counter loads the start address from the opcode: 0 gives 4, 1 gives 25, 2 gives 28, 3 gives 12, 4 gives 16, and any other opcode gives 0. When `instr_valid` is high away from address 3, it has no effect.
- R5: A branch microinstruction loads its target when the selected condition equals its polarity bit (1 means branch on true, 0 means branch on false). The selector codes are 0 for N (`flag_n`), 1 for Z (`flag_z`), 2 for memory done (`mem_done`) and 3 for always true. Three branches use this: address 13 always goes to 7, address 17 loops to itself while `mem_done` is low, and address 28 goes to 0 when Z is 0.
- R6: A branch whose condition does not match its polarity lets the counter step by one.
- R7: After a microinstruction with the End bit (bit 16) set, the counter is 0.
- R8: Each control signal has its own bit, and every bit not named in a step is 0. The bits are: 0 PC drive, 1 PC load, 2 MAR load, 3 read, 4 MDR drive, 5 IR load, 6 Y load, 7 ALU A select (1 = constant 4, 0 = Y), 8 add, 9 Z load, 10 Z drive, 11 R1 drive, 12 R1 load, 13 R3 drive, 14 IR offset drive, 15 wait for memory, 16 End. So address 1 gives 0x08442, address 26 gives 0x04300 and address 27 gives 0x10402.
- R9: The branch-if-negative routine (opcode 1) behaves as follows. With N=0 it goes 25 to 0. With N=1 it goes 25, 26, 27, 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_valid | input | 1 | Opcode stream valid |
| instr_ready | output | 1 | Opcode stream ready, high at dispatch |
| instr_opcode | input | 4 | Opcode of the instruction in IR |
| flag_n | input | 1 | Negative condition code |
| flag_z | input | 1 | Zero condition code |
| mem_done | input | 1 | Memory operation complete |
| ctrl_word | output | 17 | Control word of the current microinstruction |
| upc_addr | output | 5 | Current microprogram counter |

## Verification
The assertions require only that the inputs are known at each rising edge. They make no demand on `instr_valid`, `mem_done` or the flags, because the design has to cope with any value of these at any time. The stimulus changes inputs only at falling edges. It drives `instr_valid` high both at dispatch and away from it, which exercises the accepted case and the ignored case. It also holds `mem_done` low across the wait states and the polling branch, so the hold paths are exercised.

// File: rtl/useq_pkg.sv
`timescale 1ns/1ps
package useq_pkg;
  localparam int UADDR_W = 5;
  localparam int DEPTH   = 1 << UADDR_W;
  localparam int CTRL_W  = 17;
  localparam int OPC_W   = 4;
  localparam logic [UADDR_W-1:0] DISPATCH_ADDR = UADDR_W'(3);

  // control bit positions
  localparam int CB_PC_OUT  = 0;
  localparam int CB_PC_IN   = 1;
  localparam int CB_MAR_IN  = 2;
  localparam int CB_READ    = 3;
  localparam int CB_MDR_OUT = 4;
  localparam int CB_IR_IN   = 5;
  localparam int CB_Y_IN    = 6;
  localparam int CB_SEL_K4  = 7;
  localparam int CB_ADD     = 8;
  localparam int CB_Z_IN    = 9;
  localparam int CB_Z_OUT   = 10;
  localparam int CB_R1_OUT  = 11;
  localparam int CB_R1_IN   = 12;
  localparam int CB_R3_OUT  = 13;
  localparam int CB_OFS_OUT = 14;
  localparam int CB_WAIT    = 15;
  localparam int CB_END     = 16;

  typedef enum logic [1:0] {
    COND_NEG  = 2'd0,
    COND_ZERO = 2'd1,
    COND_MEM  = 2'd2,
    COND_ONE  = 2'd3
  } cond_e;

  typedef struct packed {
    logic [CTRL_W-1:0]  ctrl;
    logic               br_en;
    cond_e              cond;
    logic               br_pol;
    logic               dispatch;
    logic [UADDR_W-1:0] target;
  } uinstr_t;

  function automatic logic [CTRL_W-1:0] sig(input int idx);
    return CTRL_W'(1) << idx;
  endfunction

  function automatic uinstr_t ui_ctrl(input logic [CTRL_W-1:0] c);
    uinstr_t u;
    u = '0;
    u.ctrl = c;
    return u;
  endfunction

  function automatic uinstr_t ui_branch(input cond_e c, input logic pol,
                                        input int unsigned tgt);
    uinstr_t u;
    u = '0;
    u.br_en  = 1'b1;
    u.cond   = c;
    u.br_pol = pol;
    u.target = UADDR_W'(tgt);
    return u;
  endfunction

  // Contents of the control store, computed per address.
  function automatic uinstr_t ucode_word(input int unsigned a);
    uinstr_t u;
    case (a)
      0:  u = ui_ctrl(sig(CB_PC_OUT) | sig(CB_MAR_IN) | sig(CB_READ) |
                      sig(CB_SEL_K4) | sig(CB_ADD) | sig(CB_Z_IN));
      1:  u = ui_ctrl(sig(CB_Z_OUT) | sig(CB_PC_IN) | sig(CB_Y_IN) | sig(CB_WAIT));
      2:  u = ui_ctrl(sig(CB_MDR_OUT) | sig(CB_IR_IN));
      3:  begin u = '0; u.dispatch = 1'b1; end
      4, 16: u = ui_ctrl(sig(CB_R3_OUT) | sig(CB_MAR_IN) | sig(CB_READ));
      5:  u = ui_ctrl(sig(CB_R1_OUT) | sig(CB_Y_IN) | sig(CB_WAIT));
      6:  u = ui_ctrl(sig(CB_MDR_OUT) | sig(CB_ADD) | sig(CB_Z_IN));
      7:  u = ui_ctrl(sig(CB_Z_OUT) | sig(CB_R1_IN) | sig(CB_END));
      12: u = ui_ctrl(sig(CB_R1_OUT) | sig(CB_SEL_K4) | sig(CB_ADD) | sig(CB_Z_IN));
      13: u = ui_branch(COND_ONE, 1'b1, 7);
      17: u = ui_branch(COND_MEM, 1'b0, 17);
      18: u = ui_ctrl(sig(CB_MDR_OUT) | sig(CB_R1_IN) | sig(CB_END));
      25: u = ui_branch(COND_NEG, 1'b0, 0);
      28: u = ui_branch(COND_ZERO, 1'b0, 0);
      26, 29: u = ui_ctrl(sig(CB_OFS_OUT) | sig(CB_ADD) | sig(CB_Z_IN));
      27, 30: u = ui_ctrl(sig(CB_Z_OUT) | sig(CB_PC_IN) | sig(CB_END));
      default: u = ui_ctrl(sig(CB_END));
    endcase
    return u;
  endfunction

  function automatic logic [UADDR_W-1:0] start_addr(input logic [OPC_W-1:0] op);
    case (op)
      OPC_W'(0): return UADDR_W'(4);
      OPC_W'(1): return UADDR_W'(25);
      OPC_W'(2): return UADDR_W'(28);
      OPC_W'(3): return UADDR_W'(12);
      OPC_W'(4): return UADDR_W'(16);
      default:   return '0;
    endcase
  endfunction
endpackage

// File: rtl/uc_store.sv
`timescale 1ns/1ps
module uc_store
  import useq_pkg::*;
(
  input  logic [UADDR_W-1:0] addr,
  output uinstr_t            word
);
  uinstr_t rom [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_rom
    assign rom[i] = ucode_word(i);
  end

  assign word = rom[addr];
endmodule

// File: rtl/uc_cond.sv
`timescale 1ns/1ps
module uc_cond
  import useq_pkg::*;
(
  input  cond_e sel,
  input  logic  flag_n,
  input  logic  flag_z,
  input  logic  mem_done,
  output logic  hit
);
  always_comb begin
    case (sel)
      COND_NEG:  hit = flag_n;
      COND_ZERO: hit = flag_z;
      COND_MEM:  hit = mem_done;
      default:   hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/uc_next.sv
`timescale 1ns/1ps
module uc_next
  import useq_pkg::*;
(
  input  logic [UADDR_W-1:0] upc,
  input  logic               wait_bit,
  input  logic               end_bit,
  input  logic               dispatch,
  input  logic               br_en,
  input  logic               br_pol,
  input  logic               cond_hit,
  input  logic [UADDR_W-1:0] target,
  input  logic               mem_done,
  input  logic               instr_valid,
  input  logic [OPC_W-1:0]   instr_opcode,
  output logic               instr_ready,
  output logic [UADDR_W-1:0] nxt
);
  logic stall, taken;

  assign stall       = wait_bit && !mem_done;
  assign taken       = br_en && (cond_hit == br_pol);
  assign instr_ready = dispatch && !stall;

  always_comb begin
    if (stall)         nxt = upc;
    else if (end_bit)  nxt = '0;
    else if (dispatch) nxt = instr_valid ? start_addr(instr_opcode) : upc;
    else if (taken)    nxt = target;
    else               nxt = upc + 1'b1;
  end
endmodule

// File: rtl/uc_counter.sv
`timescale 1ns/1ps
module uc_counter
  import useq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [UADDR_W-1:0] nxt,
  output logic [UADDR_W-1:0] upc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) upc <= '0;
    else        upc <= nxt;
  end
endmodule

// File: rtl/useq_top.sv
`timescale 1ns/1ps
module useq_top
  import useq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instr_valid,
  output logic               instr_ready,
  input  logic [OPC_W-1:0]   instr_opcode,
  input  logic               flag_n,
  input  logic               flag_z,
  input  logic               mem_done,
  output logic [CTRL_W-1:0]  ctrl_word,
  output logic [UADDR_W-1:0] upc_addr
);
  logic [UADDR_W-1:0] upc, nxt;
  uinstr_t            cur_ui;
  logic               cond_hit;

  uc_counter u_cnt (.clk(clk), .rst_n(rst_n), .nxt(nxt), .upc(upc));

  uc_store u_store (.addr(upc), .word(cur_ui));

  uc_cond u_cond (
    .sel(cur_ui.cond), .flag_n(flag_n), .flag_z(flag_z),
    .mem_done(mem_done), .hit(cond_hit)
  );

  uc_next u_next (
    .upc(upc), .wait_bit(cur_ui.ctrl[CB_WAIT]), .end_bit(cur_ui.ctrl[CB_END]),
    .dispatch(cur_ui.dispatch), .br_en(cur_ui.br_en), .br_pol(cur_ui.br_pol),
    .cond_hit(cond_hit), .target(cur_ui.target), .mem_done(mem_done),
    .instr_valid(instr_valid), .instr_opcode(instr_opcode),
    .instr_ready(instr_ready), .nxt(nxt)
  );

  assign ctrl_word = cur_ui.ctrl;
  assign upc_addr  = upc;
endmodule

// File: rtl/useq_chk.sv
`timescale 1ns/1ps
module useq_chk
  import useq_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               instr_valid,
  input logic               instr_ready,
  input logic               mem_done,
  input logic [UADDR_W-1:0] upc_addr,
  input uinstr_t            cur_ui
);
  logic stalled, plain;
  assign stalled = cur_ui.ctrl[CB_WAIT] && !mem_done;
  assign plain   = !stalled && !cur_ui.ctrl[CB_END] && !cur_ui.dispatch && !cur_ui.br_en;

  a_r1_reset_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> upc_addr == '0);

  a_r2_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    plain |=> upc_addr == UADDR_W'($past(upc_addr) + 1'b1));

  a_r3_wait_hold: assert property (@(posedge clk) disable iff (!rst_n)
    stalled |=> $stable(upc_addr));

  a_r4_ready_at_dispatch: assert property (@(posedge clk) disable iff (!rst_n)
    instr_ready |-> upc_addr == DISPATCH_ADDR);

  a_r4_hold_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_ready && !instr_valid) |=> $stable(upc_addr));

  a_r5_always_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_ui.br_en && cur_ui.cond == COND_ONE && cur_ui.br_pol)
      |=> upc_addr == $past(cur_ui.target));

  a_r7_end_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_ui.ctrl[CB_END] && !stalled) |=> upc_addr == '0);
endmodule

bind useq_top useq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid),
  .instr_ready(instr_ready), .mem_done(mem_done),
  .upc_addr(upc_addr), .cur_ui(cur_ui)
);

// File: tb/useq_top_tb_top.sv
`timescale 1ns/1ps
module useq_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic        instr_ready;
  logic [3:0]  instr_opcode = '0;
  logic        flag_n = 1'b0, flag_z = 1'b0, mem_done = 1'b0;
  logic [16:0] ctrl_word;
  logic [4:0]  upc_addr;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  useq_top dut_i (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_ready(instr_ready),
    .instr_opcode(instr_opcode), .flag_n(flag_n), .flag_z(flag_z),
    .mem_done(mem_done), .ctrl_word(ctrl_word), .upc_addr(upc_addr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // vector: {req[3:0], valid, opcode[3:0], n, z, mem, expected uPC after edge[4:0]}
  localparam int NV = 46;
  localparam logic [16:0] VEC [NV] = '{
    {4'd2, 1'b0, 4'd0, 3'b000, 5'd1},   // R2 0->1
    {4'd3, 1'b0, 4'd0, 3'b000, 5'd1},   // R3 hold at 1
    {4'd3, 1'b0, 4'd0, 3'b001, 5'd2},   // R3 release
    {4'd2, 1'b0, 4'd0, 3'b001, 5'd3},
    {4'd4, 1'b0, 4'd0, 3'b000, 5'd3},   // R4 hold, no valid
    {4'd4, 1'b1, 4'd1, 3'b000, 5'd25},  // R4 dispatch opcode 1
    {4'd9, 1'b0, 4'd0, 3'b000, 5'd0},   // R9 N=0 back to fetch
    {4'd2, 1'b0, 4'd0, 3'b001, 5'd1},
    {4'd3, 1'b0, 4'd0, 3'b001, 5'd2},
    {4'd2, 1'b0, 4'd0, 3'b001, 5'd3},
    {4'd4, 1'b1, 4'd1, 3'b000, 5'd25},
    {4'd6, 1'b0, 4'd0, 3'b100, 5'd26},  // R6 N=1 falls through
    {4'd2, 1'b0, 4'd0, 3'b100, 5'd27},
    {4'd7, 1'b0, 4'd0, 3'b000, 5'd0},   // R7 End
    {4'd2, 1'b0, 4'd0, 3'b001, 5'd1},
    {4'd3, 1'b0, 4'd0, 3'b001, 5'd2},
    {4'd2, 1'b0, 4'd0, 3'b001, 5'd3},
    {4'd4, 1'b1, 4'd2, 3'b000, 5'd28},  // R4 opcode 2
    {4'd6, 1'b0, 4'd0, 3'b010, 5'd29},  // R6 Z=1 falls through
    {4'd2, 1'b0, 4'd0, 3'b000, 5'd30},
    {4'd7, 1'b0, 4'd0, 3'b000, 5'd0},
    {4'd2, 1'b0, 4'd0, 3'b001, 5'd1},
    {4'd3, 1'b0, 4'd0, 3'b001, 5'd2},
    {4'd2, 1'b0, 4'd0, 3'b001, 5'd3},
    {4'd4, 1'b1, 4'd2, 3'b000, 5'd28},
    {4'd5, 1'b0, 4'd0, 3'b000, 5'd0},   // R5 Z=0 taken
    {4'd2, 1'b0, 4'd0, 3'b001, 5'd1},
    {4'd3, 1'b0, 4'd0, 3'b001, 5'd2},
    {4'd2, 1'b0, 4'd0, 3'b001, 5'd3},
    {4'd4, 1'b1, 4'd3, 3'b000, 5'd12},  // R4 opcode 3
    {4'd2, 1'b0, 4'd0, 3'b000, 5'd13},
    {4'd5, 1'b0, 4'd0, 3'b000, 5'd7},   // R5 always branch
    {4'd7, 1'b0, 4'd0, 3'b000, 5'd0},
    {4'd2, 1'b0, 4'd0, 3'b001, 5'd1},
    {4'd3, 1'b0, 4'd0, 3'b001, 5'd2},
    {4'd2, 1'b0, 4'd0, 3'b001, 5'd3},
    {4'd4, 1'b1, 4'd4, 3'b000, 5'd16},  // R4 opcode 4
    {4'd2, 1'b0, 4'd0, 3'b000, 5'd17},
    {4'd5, 1'b0, 4'd0, 3'b000, 5'd17},  // R5 poll loop on mem low
    {4'd6, 1'b0, 4'd0, 3'b001, 5'd18},  // R6 poll exits
    {4'd7, 1'b0, 4'd0, 3'b000, 5'd0},
    {4'd2, 1'b0, 4'd0, 3'b001, 5'd1},
    {4'd3, 1'b0, 4'd0, 3'b001, 5'd2},
    {4'd2, 1'b0, 4'd0, 3'b001, 5'd3},
    {4'd4, 1'b1, 4'd9, 3'b000, 5'd0},   // R4 unmapped opcode
    {4'd4, 1'b1, 4'd1, 3'b000, 5'd1}    // R4 valid ignored at address 0
  };

  initial begin
    #(200000 * 5);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [4:0] prev_exp;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset upc", 32'(upc_addr), 32'd0);
    check("R1 reset ctrl", 32'(ctrl_word), 32'h0038D);
    check("R1 reset ready", 32'(instr_ready), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    prev_exp = '0;
    for (int i = 0; i < NV; i++) begin
      logic [16:0] v;
      string tag;
      v = VEC[i];
      @(negedge clk);
      instr_valid  = v[12];
      instr_opcode = v[11:8];
      flag_n       = v[7];
      flag_z       = v[6];
      mem_done     = v[5];
      #0.5;
      check("R4 ready level", 32'(instr_ready), 32'(prev_exp == 5'd3));
      @(posedge clk);
      #1;
      tag = $sformatf("R%0d vector %0d uPC", v[16:13], i);
      check(tag, 32'(upc_addr), 32'(v[4:0]));
      if (v[4:0] == 5'd1)  check("R8 ctrl at 1",  32'(ctrl_word), 32'h08442);
      if (v[4:0] == 5'd26) check("R8 ctrl at 26", 32'(ctrl_word), 32'h04300);
      if (v[4:0] == 5'd27) check("R8 ctrl at 27", 32'(ctrl_word), 32'h10402);
      prev_exp = v[4:0];
    end

    // Directed: reset in the middle of a routine (R1)
    @(negedge clk);
    instr_valid = 1'b0; mem_done = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    check("R2 fetch reaches 3", 32'(upc_addr), 32'd3);
    @(negedge clk);
    instr_valid = 1'b1; instr_opcode = 4'd0;
    @(posedge clk); #1;
    check("R4 opcode 0 start", 32'(upc_addr), 32'd4);
    @(negedge clk);
    instr_valid = 1'b0; mem_done = 1'b0;
    @(posedge clk); #1;
    check("R2 4 to 5", 32'(upc_addr), 32'd5);
    @(posedge clk); #1;
    check("R3 hold at 5", 32'(upc_addr), 32'd5);
    @(negedge clk);
    rst_n = 1'b0;
    #0.5;
    check("R1 async reset upc", 32'(upc_addr), 32'd0);
    check("R1 async reset ctrl", 32'(ctrl_word), 32'h0038D);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R2 after reset", 32'(upc_addr), 32'd1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule